// File: doc/BRIEF.md
# DMA Channel Result Queue and Interrupt Unit

This block keeps the completion results of a multi-channel DMA engine that is shared by several execution environments. Every (environment, channel) pair owns a small result queue. A channel that finishes a transfer reports this on a one-cycle event input, which carries the environment, the channel and an error flag. The block then queues a result word and can raise an interrupt status bit for that pair. Software in each environment sees its own register bank. From that bank it reads and pops results, inspects per-channel status, enables interrupts and flush reporting, and requests that a channel be aborted.

A write to a channel's flush register sends a one-cycle abort pulse toward the datapath. If the pair has flush reporting enabled, the same write also queues a result that carries the flushed flag. Each environment has one interrupt line, which is high while any of its channel interrupt bits is set. The register port is a plain single-cycle read/write strobe interface. Read data appears one cycle after the read strobe and is zero in every cycle that follows no read.

Top module: `dma_result_irq`

## Requirements
- R1: After reset every result queue is empty, all enables are 0, and `irq_o`, `abort_o` and `reg_rdata` are 0.
- R2: A completion event queues a result for its (environment, channel) pair. When read, that result shows valid at bit 31, transfer-done at bit 1, and error at bit 3 when `done_err` was set. Each queue holds DEPTH results, and a result that arrives while the queue is full is dropped.
- R3: The environment bank is selected by address bits [12:11], which gives a stride of 0x800. A read of offset 0x40+4*ch returns the oldest result of that pair in the next cycle and removes it. An empty queue reads 0. When a push lands in the same cycle as a read, the read still returns the old head.
- R4: Offset 0x200+4*ch reads 2 (bit 1 set) while the pair has a result waiting, and 0 otherwise.
- R5: Offset 0x300+4*ch is a configuration word that reads back as written. Bit 0 is the interrupt enable and bit 1 is the flush-result enable. Both reset to 0.
- R6: A pair's interrupt status bit is set when a result is queued while its interrupt enable is 1. It clears once a read empties the queue. While the interrupt enable is 0, results are still queued but the bit is not set.
- R7: Offset 0x380 in a bank reads the interrupt status bits of that environment, with bit i for channel i.
- R8: `irq_o[e]` is high exactly when at least one interrupt status bit of environment e is set.
- R9: A write to offset 0x80+4*ch gives `abort_o[ch]` high for the one following cycle. It queues a result with the flushed flag (bit 2, word 0x80000004) only when that pair's flush-result enable is 1.
- R10: When a completion event and a flush write reach the same pair in one cycle, the completion result is queued ahead of the flushed result.
- R11: Reads of offsets that are unmapped or not word aligned return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_valid | input | 1 | One-cycle channel completion event |
| done_ee | input | EE_W | Environment of the completion event |
| done_ch | input | CH_W | Channel of the completion event |
| done_err | input | 1 | Completion ended with an error |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address; bits [12:11] select the environment bank |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd`, otherwise 0 |
| irq_o | output | NUM_EE | Interrupt line of each environment |
| abort_o | output | NUM_CH | One-cycle abort request for each channel |

## Verification
The bench targets the moments where several things hit one queue in the same cycle. A read that pops while a completion pushes must return the old head; a design that pushes before it pops would return the wrong word or lose an entry. A completion and a flush arriving together must stay in order; a design that gets this wrong would swap the done and flushed words. The bench also fills a queue past DEPTH, and a design without the drop check would overwrite or wrap the oldest result. It covers interrupts with the enable off, where a design that ignores the enable would raise `irq_o`, and interrupts with several results pending, where a design that clears the bit on the first read would drop the line too early. It also checks that a flush with reporting disabled still aborts the channel but queues nothing, and that a result queued in one bank is not visible from another bank.

// File: rtl/dri_pkg.sv
package dri_pkg;

  localparam logic [10:0] OFF_RESULT = 11'h040;
  localparam logic [10:0] OFF_FLUSH  = 11'h080;
  localparam logic [10:0] OFF_STATUS = 11'h200;
  localparam logic [10:0] OFF_CONF   = 11'h300;
  localparam logic [10:0] OFF_IRQST  = 11'h380;
  localparam int          BANK_LSB   = 11;

  typedef enum logic [2:0] {
    RG_NONE, RG_RESULT, RG_FLUSH, RG_STATUS, RG_CONF, RG_IRQST
  } reg_kind_e;

  typedef struct packed {
    logic err;
    logic flushed;
    logic done;
  } res_flags_t;

  // result word: valid 31, error 3, flushed 2, transfer done 1
  function automatic logic [31:0] result_word(logic vld, res_flags_t f);
    return {vld, 27'b0, f.err, f.flushed, f.done, 1'b0};
  endfunction

  function automatic logic in_window(logic [10:0] off, logic [10:0] base, int nch);
    return (int'(off) >= int'(base)) && (int'(off) < int'(base) + 4 * nch);
  endfunction

  function automatic reg_kind_e region_of(logic [10:0] off, int nch);
    if (off[1:0] != 2'b00)               return RG_NONE;
    if (off == OFF_IRQST)                return RG_IRQST;
    if (in_window(off, OFF_RESULT, nch)) return RG_RESULT;
    if (in_window(off, OFF_FLUSH,  nch)) return RG_FLUSH;
    if (in_window(off, OFF_STATUS, nch)) return RG_STATUS;
    if (in_window(off, OFF_CONF,   nch)) return RG_CONF;
    return RG_NONE;
  endfunction

endpackage

// File: rtl/dri_addr_dec.sv
module dri_addr_dec
  import dri_pkg::*;
#(
  parameter int NUM_EE = 4,
  parameter int NUM_CH = 16,
  parameter int EE_W   = 2,
  parameter int CH_W   = 4,
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [EE_W-1:0]   ee,
  output logic [CH_W-1:0]   ch
);
  logic [10:0] off;

  always_comb begin
    off  = addr[10:0];
    ee   = addr[BANK_LSB +: EE_W];
    ch   = off[2 +: CH_W];
    kind = region_of(off, NUM_CH);
    if (int'(ee) >= NUM_EE) kind = RG_NONE;
  end
endmodule

// File: rtl/dri_result_q.sv
module dri_result_q
  import dri_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_a,
  input  res_flags_t       flags_a,
  input  logic             push_b,
  input  res_flags_t       flags_b,
  input  logic             pop,
  input  logic             ien,
  output res_flags_t       head,
  output logic             nempty,
  output logic             ist,
  output logic             accepted,
  output logic [CNT_W-1:0] count
);
  res_flags_t       ent   [DEPTH];
  res_flags_t       n_ent [DEPTH];
  logic [CNT_W-1:0] n_cnt;
  logic             n_ist;

  // pop first, then the completion, then the flush
  always_comb begin
    for (int i = 0; i < DEPTH; i++) n_ent[i] = ent[i];
    n_cnt    = count;
    accepted = 1'b0;
    if (pop && count != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) n_ent[i] = n_ent[i+1];
      n_ent[DEPTH-1] = '0;
      n_cnt = n_cnt - 1'b1;
    end
    if (push_a && n_cnt < CNT_W'(DEPTH)) begin
      n_ent[n_cnt] = flags_a;
      n_cnt        = n_cnt + 1'b1;
      accepted     = 1'b1;
    end
    if (push_b && n_cnt < CNT_W'(DEPTH)) begin
      n_ent[n_cnt] = flags_b;
      n_cnt        = n_cnt + 1'b1;
      accepted     = 1'b1;
    end
    n_ist = (ist && n_cnt != '0) || (accepted && ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      count <= '0;
      ist   <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= n_ent[i];
      count <= n_cnt;
      ist   <= n_ist;
    end
  end

  assign head   = ent[0];
  assign nempty = (count != '0);
endmodule

// File: rtl/dma_result_irq.sv
module dma_result_irq
  import dri_pkg::*;
#(
  parameter int NUM_EE = 4,
  parameter int NUM_CH = 16,
  parameter int DEPTH  = 2,
  localparam int EE_W   = (NUM_EE > 1) ? $clog2(NUM_EE) : 1,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = BANK_LSB + EE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_valid,
  input  logic [EE_W-1:0]   done_ee,
  input  logic [CH_W-1:0]   done_ch,
  input  logic              done_err,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_EE-1:0] irq_o,
  output logic [NUM_CH-1:0] abort_o
);
  localparam int NQ    = NUM_EE * NUM_CH;
  localparam int CNT_W = $clog2(DEPTH + 1);

  reg_kind_e         kind;
  logic [EE_W-1:0]   dec_ee;
  logic [CH_W-1:0]   dec_ch;
  logic              rd_result;
  logic              flush_hit;
  logic              conf_hit;
  logic [NUM_CH-1:0] flush_vec;
  logic [31:0]       rd_next;

  // named per-queue events, brought out for the checker
  logic [NQ-1:0]       ist_flat;
  logic [NQ-1:0]       nempty_flat;
  logic [NQ-1:0]       acc_flat;
  logic [NQ-1:0]       ien_flat;
  logic [NQ-1:0]       fen_flat;
  logic [NQ*CNT_W-1:0] cnt_flat;
  res_flags_t          head_arr [NQ];

  dri_addr_dec #(
    .NUM_EE(NUM_EE), .NUM_CH(NUM_CH), .EE_W(EE_W), .CH_W(CH_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(reg_addr), .kind(kind), .ee(dec_ee), .ch(dec_ch)
  );

  assign rd_result = reg_rd && (kind == RG_RESULT);
  assign flush_hit = reg_wr && (kind == RG_FLUSH);
  assign conf_hit  = reg_wr && (kind == RG_CONF);

  always_comb begin
    flush_vec = '0;
    if (flush_hit) flush_vec[dec_ch] = 1'b1;
  end

  for (genvar e = 0; e < NUM_EE; e++) begin : g_ee
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int K = e * NUM_CH + c;
      logic       here;
      logic       push_a;
      logic       push_b;
      res_flags_t fl_done;
      res_flags_t fl_flush;

      assign here     = (dec_ee == EE_W'(e)) && (dec_ch == CH_W'(c));
      assign push_a   = done_valid && (done_ee == EE_W'(e)) && (done_ch == CH_W'(c));
      assign push_b   = flush_hit && here && fen_flat[K];
      assign fl_done  = '{err: done_err, flushed: 1'b0, done: 1'b1};
      assign fl_flush = '{err: 1'b0, flushed: 1'b1, done: 1'b0};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ien_flat[K] <= 1'b0;
          fen_flat[K] <= 1'b0;
        end else if (conf_hit && here) begin
          ien_flat[K] <= reg_wdata[0];
          fen_flat[K] <= reg_wdata[1];
        end
      end

      dri_result_q #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_a  (push_a),
        .flags_a (fl_done),
        .push_b  (push_b),
        .flags_b (fl_flush),
        .pop     (rd_result && here),
        .ien     (ien_flat[K]),
        .head    (head_arr[K]),
        .nempty  (nempty_flat[K]),
        .ist     (ist_flat[K]),
        .accepted(acc_flat[K]),
        .count   (cnt_flat[K*CNT_W +: CNT_W])
      );
    end
    assign irq_o[e] = |ist_flat[e*NUM_CH +: NUM_CH];
  end

  always_comb begin
    int sel;
    sel     = int'(dec_ee) * NUM_CH + int'(dec_ch);
    rd_next = '0;
    if (sel < NQ) begin
      unique case (kind)
        RG_RESULT: rd_next = nempty_flat[sel] ? result_word(1'b1, head_arr[sel]) : '0;
        RG_STATUS: rd_next = {30'b0, nempty_flat[sel], 1'b0};
        RG_CONF:   rd_next = {30'b0, fen_flat[sel], ien_flat[sel]};
        RG_IRQST:  for (int c = 0; c < NUM_CH; c++)
                     rd_next[c] = ist_flat[int'(dec_ee) * NUM_CH + c];
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      abort_o   <= '0;
    end else begin
      reg_rdata <= reg_rd ? rd_next : '0;
      abort_o   <= flush_vec;
    end
  end
endmodule

// File: rtl/dri_checker.sv
module dri_checker #(
  parameter int NUM_EE = 4,
  parameter int NUM_CH = 16,
  parameter int DEPTH  = 2,
  parameter int CNT_W  = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             reg_rd,
  input logic [31:0]                      reg_rdata,
  input logic [NUM_EE-1:0]                irq_o,
  input logic [NUM_CH-1:0]                abort_o,
  input logic                             flush_hit,
  input logic [NUM_CH-1:0]                flush_vec,
  input logic [NUM_EE*NUM_CH-1:0]         ist_flat,
  input logic [NUM_EE*NUM_CH-1:0]         nempty_flat,
  input logic [NUM_EE*NUM_CH-1:0]         acc_flat,
  input logic [NUM_EE*NUM_CH-1:0]         ien_flat,
  input logic [NUM_EE*NUM_CH*CNT_W-1:0]   cnt_flat
);
  localparam int NQ = NUM_EE * NUM_CH;

  for (genvar k = 0; k < NQ; k++) begin : g_q
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_flat[k*CNT_W +: CNT_W]) <= DEPTH);
  end

  p_irq_needs_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_flat & ~nempty_flat) == '0);

  p_irq_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_flat & ~$past(ist_flat) & ~$past(acc_flat & ien_flat)) == '0);

  p_line_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nempty_flat == '0) |-> (irq_o == '0));

  p_abort_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_hit |=> (abort_o == $past(flush_vec)));

  p_abort_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(abort_o));

  p_rdata_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd) |-> (reg_rdata == '0));
endmodule

bind dma_result_irq dri_checker #(
  .NUM_EE(NUM_EE), .NUM_CH(NUM_CH), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .irq_o(irq_o), .abort_o(abort_o), .flush_hit(flush_hit), .flush_vec(flush_vec),
  .ist_flat(ist_flat), .nempty_flat(nempty_flat), .acc_flat(acc_flat),
  .ien_flat(ien_flat), .cnt_flat(cnt_flat)
);

// File: tb/tb_dma_result_irq.sv
module tb_dma_result_irq;
  localparam int CLK_PERIOD = 10;
  localparam int NEE = 4;
  localparam int NCH = 16;
  localparam int DEP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_valid = 1'b0;
  logic [1:0]  done_ee = '0;
  logic [3:0]  done_ch = '0;
  logic        done_err = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [12:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_o;
  logic [15:0] abort_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string cur_tag = "R1";

  // reference model state
  int          mq [64][$];
  bit          mien [64];
  bit          mfen [64];
  bit          mist [64];
  logic [31:0] exp_rdata = '0;
  logic [15:0] exp_abort = '0;

  dma_result_irq #(.NUM_EE(NEE), .NUM_CH(NCH), .DEPTH(DEP)) dut (
    .clk(clk), .rst_n(rst_n), .done_valid(done_valid), .done_ee(done_ee),
    .done_ch(done_ch), .done_err(done_err), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .abort_o(abort_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int adr(int ee, int base, int ch);
    return ee * 'h800 + base + ch * 4;
  endfunction

  // 0 none, 1 result, 2 flush, 3 status, 4 conf, 5 irq status
  function automatic int kind_of(int off);
    if (off % 4 != 0) return 0;
    if (off == 'h380) return 5;
    if (off >= 'h040 && off < 'h080) return 1;
    if (off >= 'h080 && off < 'h0c0) return 2;
    if (off >= 'h200 && off < 'h240) return 3;
    if (off >= 'h300 && off < 'h340) return 4;
    return 0;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    v = '0;
    for (int e = 0; e < NEE; e++)
      for (int c = 0; c < NCH; c++)
        if (mist[e*NCH+c]) v[e] = 1'b1;
    return v;
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] expv, string tag, string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic model_edge();
    int off, be, ch, k, kind;
    bit acc;
    off  = int'(reg_addr) % 'h800;
    be   = int'(reg_addr) / 'h800;
    kind = kind_of(off);
    ch   = (off / 4) % 16;
    k    = be * NCH + ch;
    exp_rdata = '0;
    if (reg_rd) begin
      case (kind)
        1: if (mq[k].size() > 0) exp_rdata = 32'h8000_0000 | 32'(mq[k][0]);
        3: if (mq[k].size() > 0) exp_rdata = 32'd2;
        4: exp_rdata = {30'b0, mfen[k], mien[k]};
        5: for (int c = 0; c < NCH; c++) exp_rdata[c] = mist[be*NCH+c];
        default: exp_rdata = '0;
      endcase
    end
    for (int q = 0; q < 64; q++) begin
      acc = 0;
      if (reg_rd && kind == 1 && q == k && mq[q].size() > 0) void'(mq[q].pop_front());
      if (done_valid && q == int'(done_ee) * NCH + int'(done_ch) && mq[q].size() < DEP) begin
        mq[q].push_back(done_err ? 10 : 2);
        acc = 1;
      end
      if (reg_wr && kind == 2 && q == k && mfen[q] && mq[q].size() < DEP) begin
        mq[q].push_back(4);
        acc = 1;
      end
      mist[q] = (mist[q] && mq[q].size() > 0) || (acc && mien[q]);
    end
    exp_abort = '0;
    if (reg_wr && kind == 2) exp_abort[ch] = 1'b1;
    if (reg_wr && kind == 4) begin
      mien[k] = reg_wdata[0];
      mfen[k] = reg_wdata[1];
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(reg_rdata, exp_rdata, cur_tag, "rdata vs model");
    check(32'(irq_o), 32'(exp_irq()), cur_tag, "irq vs model");
    check(32'(abort_o), 32'(exp_abort), cur_tag, "abort vs model");
    done_valid = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; done_err = 1'b0;
  endtask

  task automatic ev(int ee, int ch, bit err);
    done_valid = 1'b1; done_ee = 2'(ee); done_ch = 4'(ch); done_err = err;
    step();
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1'b1; reg_addr = 13'(a); reg_wdata = 32'(d);
    step();
  endtask

  task automatic rd_expect(int a, logic [31:0] expv, string tag);
    reg_rd = 1'b1; reg_addr = 13'(a);
    step();
    check(reg_rdata, expv, tag, "directed read");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_tag = "R1";
    check(32'(irq_o), 0, "R1", "irq after reset");
    check(32'(abort_o), 0, "R1", "abort after reset");
    check(reg_rdata, 0, "R1", "rdata after reset");
    rd_expect(adr(0, 'h300, 0), 0, "R1");
    rd_expect(adr(0, 'h380, 0), 0, "R1");
    rd_expect(adr(2, 'h200, 9), 0, "R1");

    // R6 disabled interrupt, result still queued; R4 status; R2 word
    cur_tag = "R6";
    ev(0, 3, 0);
    check(32'(irq_o), 0, "R6", "no irq while disabled");
    rd_expect(adr(0, 'h200, 3), 2, "R4");
    rd_expect(adr(0, 'h040, 3), 32'h8000_0002, "R2");
    rd_expect(adr(0, 'h200, 3), 0, "R4");
    rd_expect(adr(0, 'h040, 3), 0, "R3");

    // R5 config readback, R7 irq status, R8 line
    cur_tag = "R5";
    wr(adr(1, 'h300, 5), 1);
    rd_expect(adr(1, 'h300, 5), 1, "R5");
    cur_tag = "R8";
    ev(1, 5, 1);
    check(32'(irq_o), 32'h2, "R8", "irq line of env1");
    rd_expect(adr(1, 'h380, 0), 32'h20, "R7");
    rd_expect(adr(0, 'h380, 0), 0, "R7");
    rd_expect(adr(1, 'h040, 5), 32'h8000_000A, "R2");
    check(32'(irq_o), 0, "R6", "irq clears when queue empties");

    // R6 two pending results
    cur_tag = "R6";
    ev(1, 5, 0);
    ev(1, 5, 0);
    rd_expect(adr(1, 'h040, 5), 32'h8000_0002, "R6");
    check(32'(irq_o), 32'h2, "R6", "irq held with one left");
    rd_expect(adr(1, 'h040, 5), 32'h8000_0002, "R6");
    check(32'(irq_o), 0, "R6", "irq after last pop");

    // R2 overflow drop
    cur_tag = "R2";
    ev(0, 9, 0); ev(0, 9, 1); ev(0, 9, 0);
    rd_expect(adr(0, 'h040, 9), 32'h8000_0002, "R2");
    rd_expect(adr(0, 'h040, 9), 32'h8000_000A, "R2");
    rd_expect(adr(0, 'h040, 9), 0, "R2");

    // R9 flush with and without reporting
    cur_tag = "R9";
    wr(adr(2, 'h300, 7), 3);
    wr(adr(2, 'h080, 7), 0);
    check(32'(abort_o), 32'h80, "R9", "abort pulse ch7");
    check(32'(irq_o), 32'h4, "R9", "flush result raises irq");
    rd_expect(adr(2, 'h040, 7), 32'h8000_0004, "R9");
    wr(adr(3, 'h300, 1), 1);
    wr(adr(3, 'h080, 1), 0);
    check(32'(abort_o), 32'h2, "R9", "abort pulse ch1");
    check(32'(irq_o), 0, "R9", "no flush result when disabled");
    rd_expect(adr(3, 'h200, 1), 0, "R9");

    // R10 completion and flush together
    cur_tag = "R10";
    done_valid = 1'b1; done_ee = 2'd2; done_ch = 4'd7; done_err = 1'b0;
    reg_wr = 1'b1; reg_addr = 13'(adr(2, 'h080, 7));
    step();
    rd_expect(adr(2, 'h040, 7), 32'h8000_0002, "R10");
    rd_expect(adr(2, 'h040, 7), 32'h8000_0004, "R10");

    // R3 bank isolation and pop with simultaneous push
    cur_tag = "R3";
    ev(0, 2, 0);
    rd_expect(adr(3, 'h040, 2), 0, "R3");
    rd_expect(adr(0, 'h040, 2), 32'h8000_0002, "R3");
    ev(0, 4, 0);
    done_valid = 1'b1; done_ee = 2'd0; done_ch = 4'd4; done_err = 1'b1;
    reg_rd = 1'b1; reg_addr = 13'(adr(0, 'h040, 4));
    step();
    check(reg_rdata, 32'h8000_0002, "R3", "old head on pop+push");
    rd_expect(adr(0, 'h040, 4), 32'h8000_000A, "R3");

    // R11 unmapped and misaligned
    cur_tag = "R11";
    rd_expect('h010, 0, "R11");
    rd_expect(adr(0, 'h042, 0), 0, "R11");
    rd_expect(adr(1, 'h384, 0), 0, "R11");

    // mixed stimulus against the model
    cur_tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      int bases [5] = '{'h040, 'h080, 'h200, 'h300, 'h380};
      done_valid = ($urandom % 10) < 3;
      done_ee = 2'($urandom % 4); done_ch = 4'($urandom % 4);
      done_err = $urandom % 2;
      sel = $urandom % 10;
      reg_addr = 13'(adr($urandom % 4, bases[$urandom % 5], $urandom % 4));
      reg_wdata = 32'($urandom % 4);
      if (sel < 4) reg_rd = 1'b1;
      else if (sel < 6) reg_wr = 1'b1;
      cur_tag = (i % 2 == 0) ? "R6" : "R9";
      step();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule